// File: doc/BRIEF.md
# Tag-Synchronized Word Memory

A small word memory in which each data word carries one presence tag saying whether the word is "full" (holds a value waiting to be consumed) or "empty" (free to be written). Plain loads and stores access data while leaving the tag alone. Two blocking operations build synchronization on the tag: a *take* waits until the word is full, returns it and marks it empty; a *put* waits until the word is empty, writes it and marks it full. Two setup operations write a word and force its tag to a chosen state.

A request that cannot finish yet is not bounced back to the requester. It is parked in a small waiter list. When a word's tag flips, the oldest parked request on that address that the flip unblocks is replayed in the next cycle, ahead of any new request. A take followed by a put on the same word is therefore an atomic read-modify-write. Producer/consumer hand-off and shared counters need no software locking.

One operation executes per cycle. Each completed operation returns the requester's thread id, the word's contents after the operation and its tag after the operation, one cycle later on a registered completion port.

Top module: `fe_sync_mem`

## Requirements
- R1: After reset every word's tag is full, `req_ready` is high and `cpl_valid` is low.
- R2: Opcode 0 (load) returns the word and its tag, and opcode 1 (store) writes the word. Neither waits on the tag or changes it, whatever its state.
- R3: Opcode 2 (take) on a full word completes at once, returns the stored data and leaves the tag empty (cpl_tag 0).
- R4: A take on an empty word produces no completion until the word is made full. It then completes with the new data and leaves the word empty.
- R5: Opcode 3 (put) on an empty word completes at once, stores the data and leaves the tag full (cpl_tag 1).
- R6: A put on a full word produces no completion until the word is made empty. It then stores its data and sets the word full.
- R7: When a word's tag flips, only the oldest parked request on that address that the flip unblocks is replayed. Parked requests on other addresses stay parked, and same-address waiters are served first-come first-served.
- R8: While the waiter list (WAIT_N entries) is full, `req_ready` is low for take and put and stays high for the other opcodes.
- R9: Opcode 4 writes the data and sets the tag empty, and opcode 5 writes the data and sets the tag full. Both complete at once and wake a waiter if the tag flips.
- R10: Several threads that each take, decrement and put the same word lose no update. The final value equals the start value minus the number of threads.
- R11: A completion appears in the cycle after its request is accepted. A replay runs in the cycle after the tag flip, and `req_ready` is low during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_op | input | 3 | Opcode: 0 load, 1 store, 2 take, 3 put, 4 set-empty, 5 set-full (6, 7 act as load) |
| req_addr | input | ADDR_W | Word address |
| req_data | input | DATA_W | Write data |
| req_tid | input | TID_W | Requesting thread id |
| cpl_valid | output | 1 | Completion present (one cycle) |
| cpl_tid | output | TID_W | Thread id of the completed request |
| cpl_data | output | DATA_W | Word contents after the operation |
| cpl_tag | output | 1 | Word tag after the operation (1 full) |

## Verification
The assertions take the request interface to be well behaved: a request is held stable while `req_valid` is high and `req_ready` is low, and the address is always inside the array. They also take a replayed waiter to be served only from a tag state that the flip itself created. This holds because nothing else executes between the flip and the replay. The stimulus drives and withdraws requests only at falling edges, holds each request until it is accepted, and reads every word only after storing to it or setting it up. It never parks more waiters than the list holds, except in the one deliberate probe of the full-list refusal, where it withdraws the request.

// File: rtl/fem_pkg.sv
package fem_pkg;
  typedef logic [2:0] op_t;
  localparam op_t OP_LOAD  = 3'd0;
  localparam op_t OP_STORE = 3'd1;
  localparam op_t OP_TAKE  = 3'd2;
  localparam op_t OP_PUT   = 3'd3;
  localparam op_t OP_SETE  = 3'd4;
  localparam op_t OP_SETF  = 3'd5;

  function automatic logic op_may_block(op_t op);
    return (op == OP_TAKE) || (op == OP_PUT);
  endfunction
endpackage

// File: rtl/fem_words.sv
module fem_words #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 4,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tag_we,
  input  logic              tag_val,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_tag,
  output logic [DEPTH-1:0]  tags_q
);
  logic [DATA_W-1:0] mem [DEPTH];

  // data array: no reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) tags_q <= '1;
    else if (tag_we) tags_q[addr] <= tag_val;
  end

  assign rd_data = mem[addr];
  assign rd_tag  = tags_q[addr];
endmodule

// File: rtl/fem_waitlist.sv
module fem_waitlist #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 4,
  parameter int TID_W  = 4,
  parameter int WAIT_N = 4,
  localparam int IW = (WAIT_N > 1) ? $clog2(WAIT_N) : 1,
  localparam int CW = $clog2(WAIT_N + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              push_put,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [DATA_W-1:0] push_data,
  input  logic [TID_W-1:0]  push_tid,
  input  logic              q_valid,
  input  logic [ADDR_W-1:0] q_addr,
  input  logic              q_put,
  output logic              hit,
  output logic [DATA_W-1:0] hit_data,
  output logic [TID_W-1:0]  hit_tid,
  output logic              full
);
  logic              e_put  [WAIT_N];
  logic [ADDR_W-1:0] e_addr [WAIT_N];
  logic [DATA_W-1:0] e_data [WAIT_N];
  logic [TID_W-1:0]  e_tid  [WAIT_N];
  logic [CW-1:0]     cnt;
  logic [IW-1:0]     hit_idx;

  // lowest matching index is the oldest entry (list kept in arrival order)
  always_comb begin
    hit = 1'b0;
    hit_idx = '0;
    for (int i = WAIT_N - 1; i >= 0; i--) begin
      if (q_valid && i < int'(cnt) && e_addr[i] == q_addr && e_put[i] == q_put) begin
        hit = 1'b1;
        hit_idx = IW'(i);
      end
    end
  end

  assign hit_data = e_data[hit_idx];
  assign hit_tid  = e_tid[hit_idx];
  assign full     = (cnt == CW'(WAIT_N));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (hit) begin
      for (int i = 0; i < WAIT_N - 1; i++) begin
        if (i >= int'(hit_idx)) begin
          e_put[i]  <= e_put[i+1];
          e_addr[i] <= e_addr[i+1];
          e_data[i] <= e_data[i+1];
          e_tid[i]  <= e_tid[i+1];
        end
      end
      cnt <= cnt - 1'b1;
    end else if (push && !full) begin
      e_put[IW'(cnt)]  <= push_put;
      e_addr[IW'(cnt)] <= push_addr;
      e_data[IW'(cnt)] <= push_data;
      e_tid[IW'(cnt)]  <= push_tid;
      cnt <= cnt + 1'b1;
    end
  end

  // R8: the list is never asked to hold more than WAIT_N waiters
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
    push |-> (cnt < CW'(WAIT_N)));
  // R7: a replay is only ever taken from a non-empty list
  a_r7_pop_has_entry: assert property (@(posedge clk) disable iff (rst)
    hit |-> (cnt != '0));
  // R7: replay and park never meet in one cycle
  a_r7_no_push_on_pop: assert property (@(posedge clk) disable iff (rst)
    hit |-> !push);
endmodule

// File: rtl/fe_sync_mem.sv
module fe_sync_mem
  import fem_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 4,
  parameter int TID_W  = 4,
  parameter int WAIT_N = 4,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic [TID_W-1:0]  req_tid,
  output logic              cpl_valid,
  output logic [TID_W-1:0]  cpl_tid,
  output logic [DATA_W-1:0] cpl_data,
  output logic              cpl_tag
);
  // pending wake: address whose tag flipped last cycle and its new tag
  logic              wk_v, wk_full;
  logic [ADDR_W-1:0] wk_addr;

  logic              wl_hit, wl_full, wl_push;
  logic [DATA_W-1:0] wl_data;
  logic [TID_W-1:0]  wl_tid;

  logic              accept, ex_v, stall, done;
  op_t               ex_op;
  logic [ADDR_W-1:0] ex_addr;
  logic [DATA_W-1:0] ex_data;
  logic [TID_W-1:0]  ex_tid;
  logic              wr_en, tag_we, tag_val;
  logic [DATA_W-1:0] rd_data;
  logic              rd_tag;
  logic [DEPTH-1:0]  tags_q;

  assign req_ready = !wl_hit && !(wl_full && op_may_block(op_t'(req_op)));
  assign accept    = req_valid && req_ready;

  // a replay has priority over a new request
  always_comb begin
    ex_v = wl_hit || accept;
    if (wl_hit) begin
      ex_op   = wk_full ? OP_TAKE : OP_PUT;
      ex_addr = wk_addr;
      ex_data = wl_data;
      ex_tid  = wl_tid;
    end else begin
      ex_op   = op_t'(req_op);
      ex_addr = req_addr;
      ex_data = req_data;
      ex_tid  = req_tid;
    end
  end

  assign stall = ex_v && ((ex_op == OP_TAKE && !rd_tag) || (ex_op == OP_PUT && rd_tag));
  assign done  = ex_v && !stall;
  assign wl_push = stall && !wl_hit;

  assign wr_en   = done && (ex_op == OP_STORE || ex_op == OP_PUT ||
                            ex_op == OP_SETE  || ex_op == OP_SETF);
  assign tag_we  = done && (ex_op == OP_TAKE || ex_op == OP_PUT ||
                            ex_op == OP_SETE || ex_op == OP_SETF);
  assign tag_val = (ex_op == OP_PUT) || (ex_op == OP_SETF);

  fem_words #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_words (
    .clk(clk), .rst(rst), .addr(ex_addr), .wr_en(wr_en), .wr_data(ex_data),
    .tag_we(tag_we), .tag_val(tag_val), .rd_data(rd_data), .rd_tag(rd_tag),
    .tags_q(tags_q)
  );

  fem_waitlist #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .TID_W(TID_W), .WAIT_N(WAIT_N)) u_wait (
    .clk(clk), .rst(rst), .push(wl_push), .push_put(ex_op == OP_PUT),
    .push_addr(ex_addr), .push_data(ex_data), .push_tid(ex_tid),
    .q_valid(wk_v), .q_addr(wk_addr), .q_put(!wk_full),
    .hit(wl_hit), .hit_data(wl_data), .hit_tid(wl_tid), .full(wl_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wk_v      <= 1'b0;
      wk_full   <= 1'b1;
      wk_addr   <= '0;
      cpl_valid <= 1'b0;
      cpl_tid   <= '0;
      cpl_data  <= '0;
      cpl_tag   <= 1'b1;
    end else begin
      wk_v      <= tag_we && (tag_val != rd_tag);
      wk_full   <= tag_val;
      wk_addr   <= ex_addr;
      cpl_valid <= done;
      cpl_tid   <= ex_tid;
      cpl_data  <= wr_en ? ex_data : rd_data;
      cpl_tag   <= tag_we ? tag_val : rd_tag;
    end
  end

  // R11: a replayed waiter always finds the tag state the flip created
  a_r11_replay_never_stalls: assert property (@(posedge clk) disable iff (rst)
    wl_hit |-> !stall);
  // R2: plain load/store leave every tag untouched
  a_r2_plain_keeps_tags: assert property (@(posedge clk) disable iff (rst)
    (done && (ex_op == OP_LOAD || ex_op == OP_STORE)) |=> (tags_q == $past(tags_q)));
  // R3: a completed take leaves its word empty
  a_r3_take_empties: assert property (@(posedge clk) disable iff (rst)
    (done && ex_op == OP_TAKE) |=> (cpl_valid && !cpl_tag));
  // R5: a completed put leaves its word full
  a_r5_put_fills: assert property (@(posedge clk) disable iff (rst)
    (done && ex_op == OP_PUT) |=> (cpl_valid && cpl_tag));
endmodule

// File: tb/sim_fe_sync_mem.sv
module sim_fe_sync_mem;
  localparam int DW = 64;
  localparam int AW = 4;
  localparam int TW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [2:0]    req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic [TW-1:0] req_tid = '0;
  logic          cpl_valid;
  logic [TW-1:0] cpl_tid;
  logic [DW-1:0] cpl_data;
  logic          cpl_tag;

  int checks = 0;
  int errors = 0;
  bit ended = 0;

  logic [TW-1:0] q_tid [$];
  logic [DW-1:0] q_data[$];
  logic          q_tag [$];
  string         q_req [$];

  always #5 clk = ~clk;

  fe_sync_mem #(.DATA_W(DW), .ADDR_W(AW), .TID_W(TW), .WAIT_N(4)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data), .req_tid(req_tid),
    .cpl_valid(cpl_valid), .cpl_tid(cpl_tid), .cpl_data(cpl_data), .cpl_tag(cpl_tag)
  );

  task automatic chk(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic expect_cpl(logic [TW-1:0] t, logic [DW-1:0] d, logic g, string req);
    q_tid.push_back(t); q_data.push_back(d); q_tag.push_back(g); q_req.push_back(req);
  endtask

  // called at a falling edge; returns at the falling edge after acceptance
  task automatic issue(logic [2:0] op, logic [AW-1:0] a, logic [DW-1:0] d, logic [TW-1:0] t);
    bit r;
    req_valid = 1'b1; req_op = op; req_addr = a; req_data = d; req_tid = t;
    do begin
      r = req_ready;
      @(negedge clk);
    end while (!r);
    req_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pop and compare each completion
  always @(negedge clk) begin
    if (!rst && cpl_valid) begin
      if (q_tid.size() == 0) begin
        chk(0, "R4", "unexpected completion tid", DW'(cpl_tid), '0);
      end else begin
        string rq;
        logic [TW-1:0] et;
        logic [DW-1:0] ed;
        logic eg;
        et = q_tid.pop_front(); ed = q_data.pop_front();
        eg = q_tag.pop_front(); rq = q_req.pop_front();
        chk(cpl_tid == et, rq, "cpl_tid", DW'(cpl_tid), DW'(et));
        chk(cpl_data == ed, rq, "cpl_data", cpl_data, ed);
        chk(cpl_tag == eg, rq, "cpl_tag", DW'(cpl_tag), DW'(eg));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(req_ready == 1'b1, "R1", "req_ready after reset", DW'(req_ready), 1);
    chk(cpl_valid == 1'b0, "R1", "cpl_valid after reset", DW'(cpl_valid), 0);

    // R1/R2: store keeps reset tag full, load returns it
    expect_cpl(1, 64'hA5A5, 1, "R2"); issue(3'd1, 5, 64'hA5A5, 1);
    // R11: completion visible in the cycle after acceptance
    chk(cpl_valid && cpl_tid == 1, "R11", "completion one cycle after accept", DW'(cpl_valid), 1);
    expect_cpl(2, 64'hA5A5, 1, "R1"); issue(3'd0, 5, 0, 2);
    // R3: take on full word
    expect_cpl(3, 64'hA5A5, 0, "R3"); issue(3'd2, 5, 0, 3);
    // R2: load and store on an empty word neither wait nor change the tag
    expect_cpl(4, 64'hA5A5, 0, "R2"); issue(3'd0, 5, 0, 4);
    expect_cpl(5, 64'hB0B0, 0, "R2"); issue(3'd1, 5, 64'hB0B0, 5);
    idle(3);

    // R9 set-empty, R5 put on empty
    expect_cpl(1, 64'hC1, 0, "R9"); issue(3'd4, 6, 64'hC1, 1);
    expect_cpl(2, 64'hD2, 1, "R5"); issue(3'd3, 6, 64'hD2, 2);
    // R6: put on full word parks, runs after a take empties it
    issue(3'd3, 6, 64'hE3, 3);
    idle(3);
    chk(cpl_valid == 1'b0, "R6", "parked put produced no completion", DW'(cpl_valid), 0);
    expect_cpl(4, 64'hD2, 0, "R6");
    expect_cpl(3, 64'hE3, 1, "R6");
    issue(3'd2, 6, 0, 4);
    idle(3);

    // R4: take on empty word 5 parks until set-full
    issue(3'd2, 5, 0, 5);
    idle(3);
    chk(cpl_valid == 1'b0, "R4", "parked take produced no completion", DW'(cpl_valid), 0);
    expect_cpl(6, 64'hF6, 1, "R9");
    expect_cpl(5, 64'hF6, 0, "R4");
    issue(3'd5, 5, 64'hF6, 6);
    chk(req_ready == 1'b0, "R11", "ready low in replay cycle", DW'(req_ready), 0);
    @(negedge clk);
    chk(cpl_valid && cpl_tid == 5, "R11", "replay completes next cycle", DW'(cpl_tid), 5);
    idle(3);

    // R7: oldest same-address waiter first, other address untouched
    expect_cpl(1, 0, 0, "R9"); issue(3'd4, 7, 0, 1);
    expect_cpl(1, 0, 0, "R9"); issue(3'd4, 8, 0, 1);
    issue(3'd2, 7, 0, 2);
    issue(3'd2, 7, 0, 3);
    issue(3'd2, 8, 0, 4);
    expect_cpl(5, 64'h77, 1, "R7"); expect_cpl(2, 64'h77, 0, "R7");
    issue(3'd3, 7, 64'h77, 5);
    idle(3);
    expect_cpl(6, 64'h78, 1, "R7"); expect_cpl(3, 64'h78, 0, "R7");
    issue(3'd3, 7, 64'h78, 6);
    idle(3);
    expect_cpl(7, 64'h88, 1, "R7"); expect_cpl(4, 64'h88, 0, "R7");
    issue(3'd5, 8, 64'h88, 7);
    idle(3);

    // R8: full waiter list refuses take/put, accepts others
    expect_cpl(0, 0, 0, "R9"); issue(3'd4, 9, 0, 0);
    for (int k = 1; k <= 4; k++) issue(3'd2, 9, 0, TW'(k));
    idle(2);
    req_valid = 1'b1; req_op = 3'd2; req_addr = 10; req_tid = 9;
    #1;
    chk(req_ready == 1'b0, "R8", "ready for take with list full", DW'(req_ready), 0);
    req_op = 3'd3;
    #1;
    chk(req_ready == 1'b0, "R8", "ready for put with list full", DW'(req_ready), 0);
    req_op = 3'd0;
    #1;
    chk(req_ready == 1'b1, "R8", "ready for load with list full", DW'(req_ready), 1);
    req_valid = 1'b0;
    @(negedge clk);
    chk(cpl_valid == 1'b0, "R8", "withdrawn probe produced nothing", DW'(cpl_valid), 0);
    expect_cpl(5, 64'h91, 1, "R8"); expect_cpl(1, 64'h91, 0, "R8");
    issue(3'd5, 9, 64'h91, 5);
    for (int k = 2; k <= 4; k++) begin
      expect_cpl(TW'(k + 4), DW'(64'h90 + k), 1, "R8");
      expect_cpl(TW'(k), DW'(64'h90 + k), 0, "R7");
      issue(3'd3, 9, DW'(64'h90 + k), TW'(k + 4));
    end
    idle(3);

    // R10: three threads take, decrement and put one counter
    v = 10;
    expect_cpl(0, v, 1, "R9"); issue(3'd5, 11, v, 0);
    expect_cpl(1, v, 0, "R10");
    issue(3'd2, 11, 0, 1);
    issue(3'd2, 11, 0, 2);
    issue(3'd2, 11, 0, 3);
    for (int k = 1; k <= 3; k++) begin
      v = v - 1;
      expect_cpl(TW'(k), v, 1, "R10");
      if (k < 3) expect_cpl(TW'(k + 1), v, 0, "R10");
      issue(3'd3, 11, v, TW'(k));
    end
    expect_cpl(0, 64'd7, 1, "R10"); issue(3'd0, 11, 0, 0);
    idle(4);

    chk(q_tid.size() == 0, "R4", "expected completions left over", DW'(q_tid.size()), 0);
    finish_run();
  end
endmodule